// File: doc/BRIEF.md
# Disk Controller I/O Command Decoder

This block sits between a processor's I/O instruction path and a cartridge-disk controller. Each I/O request carries a 3-bit sub-operation code and a 12-bit accumulator value. The block keeps four 12-bit registers: status, command, disk address and memory address. It also keeps the controller busy flag. It answers every request one cycle later with a skip flag and a 12-bit value for the accumulator. It drives a level interrupt request continuously.

Starting a transfer or a seek is not done here. The block emits a registered one-cycle start pulse that carries a function code, a cylinder number and a drive select. A separate launch block acts on that pulse. The launch block and the service logic report results back through a status OR-in port and through busy set and clear strobes. The selected drive's attached and active flags come in as plain vectors. The command, disk-address and memory-address registers are exported for the data mover.

The request side is a plain strobe, `iot_valid`. There is no ready signal, so there is no back-pressure. `rsp_valid` is a single-cycle pulse one cycle after the strobe, and the requester must take the response in that cycle. Requests may arrive on consecutive cycles.

Top module: `dkc_iot_decoder`

## Requirements
- R1: Sub-op 1 gives `rsp_skip`=1 when the status register holds a value with any bit of the mask 12'o4177 set. That mask is done at bit 11 plus the seven error bits [6:0], with busy error at bit 6. Otherwise `rsp_skip` is 0. No other sub-op raises skip.
- R2: Sub-op 2 always clears the status register, and the mode comes from `iot_ac[1:0]`. In mode 0, busy error (bit 6) is then set if the controller is busy. Mode 3 only clears status.
- R3: Sub-op 2 mode 1 zeroes the command, disk-address and memory-address registers and the busy flag. It also pulses `cancel_all` for one cycle.
- R4: Sub-op 2 mode 2 sets busy error if the controller is busy. Otherwise it issues a start with function 3 (seek), cylinder 0, and the drive selected by command bits [2:1].
- R5: Sub-op 3, when not busy, loads the disk address from `iot_ac`. It then issues a start with function = command[11:9], cylinder = {command[0], iot_ac[11:5]} and drive = command[2:1].
- R6: Sub-op 4, when not busy, loads the memory address from `iot_ac`. Sub-op 6, when not busy, loads the command register from `iot_ac` and clears status.
- R7: While busy, sub-ops 3, 4 and 6 leave every register unchanged except status, where they set busy error (bit 6). They issue no start.
- R8: Sub-op 5 clears status bits 10 (heads moving) and 7 (not ready). It then sets bit 7 if the drive selected by command[2:1] is not attached, and sets bit 10 if that drive is active. It returns the resulting status on `rsp_ac`.
- R9: `irq` is 1 exactly when status has any bit of 12'o4177 set and command bit 8 is 1. It follows every register change.
- R10: `rsp_ac` is zero for every sub-op except 5. Sub-ops 0 and 7 change no state.
- R11: Reset clears all four registers, the busy flag, `irq`, the response and the start and cancel pulses.
- R12: `go_pulse` and `rsp_valid` are high for exactly one cycle, starting in the cycle after the request strobe. `go_func`, `go_cyl` and `go_drive` are valid while `go_pulse` is high.
- R13: `ext_busy_set` sets the busy flag and `ext_busy_clr` clears it, with set winning over clear. Sub-op 2 mode 1 wins over both. `ext_sta_set` is ORed into status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_valid | input | 1 | Request strobe, one request per high cycle |
| iot_op | input | 3 | Sub-operation code |
| iot_ac | input | 12 | Accumulator value supplied with the request |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_skip | output | 1 | Skip answer (sub-op 1) |
| rsp_ac | output | 12 | Value written back to the accumulator |
| irq | output | 1 | Level interrupt request |
| drv_attached | input | NUM_DRIVES | Per-drive attached flags |
| drv_active | input | NUM_DRIVES | Per-drive active (positioning) flags |
| ext_sta_set | input | 12 | Status bits to OR in from the launch/service side |
| ext_busy_set | input | 1 | Set the controller busy flag |
| ext_busy_clr | input | 1 | Clear the controller busy flag |
| ctl_busy | output | 1 | Controller busy flag |
| cmd_word | output | 12 | Command register |
| disk_addr | output | 12 | Disk address register |
| mem_addr | output | 12 | Memory address register |
| go_pulse | output | 1 | One-cycle start request to the launch block |
| go_func | output | 3 | Function code for the start |
| go_cyl | output | 8 | Cylinder number for the start |
| go_drive | output | $clog2(NUM_DRIVES) | Drive select for the start |
| cancel_all | output | 1 | One-cycle request to stop activity on all drives |

## Verification
The bench builds the block with the default NUM_DRIVES=4. At that size every drive select value can be paired with every combination of attached and active flags. It sweeps all eight sub-ops over a few hundred accumulator patterns. These sweeps reach all four clear modes, every command function and both cylinder high-bit values, with the controller both idle and busy. Injected status patterns bring the skip and interrupt conditions across both states of the enable bit. Expected register, start and response values come from an arithmetic model of the requirements.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int WORD_W     = 12;
  localparam int FUNC_LSB   = 9;
  localparam int FUNC_W     = 3;
  localparam int IE_BIT     = 8;
  localparam int SEL_LSB    = 1;
  localparam int CYHI_BIT   = 0;
  localparam int DA_CYL_LSB = 5;
  localparam int CYL_W      = 1 + WORD_W - DA_CYL_LSB;

  localparam int ST_DONE    = 11;
  localparam int ST_HMOV    = 10;
  localparam int ST_NRDY    = 7;
  localparam int ST_BUSYERR = 6;

  localparam logic [WORD_W-1:0] ERR_MASK  = 12'o0177;
  localparam logic [WORD_W-1:0] ATTN_MASK = ERR_MASK | (WORD_W'(1) << ST_DONE);
  localparam logic [FUNC_W-1:0] FN_SEEK   = 3'd3;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SKIP     = 3'd1,
    OP_CLEAR    = 3'd2,
    OP_LOAD_GO  = 3'd3,
    OP_LOAD_MA  = 3'd4,
    OP_PROBE    = 3'd5,
    OP_LOAD_CMD = 3'd6,
    OP_SPARE    = 3'd7
  } iot_op_e;

  typedef enum logic [1:0] {
    CLR_STATUS     = 2'd0,
    CLR_CONTROL    = 2'd1,
    CLR_DRIVE      = 2'd2,
    CLR_STATUS_ALT = 2'd3
  } clr_mode_e;

  typedef struct packed {
    logic attn_skip;
    logic clr_sta;
    logic refuse;
    logic clr_ctl;
    logic ld_da;
    logic ld_ma;
    logic ld_cmd;
    logic probe;
    logic go_xfer;
    logic go_recal;
  } iot_ctl_t;
endpackage

// File: rtl/dkc_op_decode.sv
module dkc_op_decode
  import dkc_pkg::*;
(
  input  logic             valid,
  input  logic [2:0]       op,
  input  logic [1:0]       mode,
  input  logic             busy,
  output iot_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    if (valid) begin
      case (iot_op_e'(op))
        OP_SKIP: ctl.attn_skip = 1'b1;
        OP_CLEAR: begin
          ctl.clr_sta = 1'b1;
          case (clr_mode_e'(mode))
            CLR_STATUS:  ctl.refuse = busy;
            CLR_CONTROL: ctl.clr_ctl = 1'b1;
            CLR_DRIVE: begin
              ctl.refuse   = busy;
              ctl.go_recal = !busy;
            end
            default: ;
          endcase
        end
        OP_LOAD_GO: begin
          ctl.refuse  = busy;
          ctl.ld_da   = !busy;
          ctl.go_xfer = !busy;
        end
        OP_LOAD_MA: begin
          ctl.refuse = busy;
          ctl.ld_ma  = !busy;
        end
        OP_PROBE: ctl.probe = 1'b1;
        OP_LOAD_CMD: begin
          ctl.refuse  = busy;
          ctl.ld_cmd  = !busy;
          ctl.clr_sta = !busy;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dkc_drive_probe.sv
module dkc_drive_probe #(
  parameter int NUM_DRIVES = 4,
  localparam int SEL_W = $clog2(NUM_DRIVES)
) (
  input  logic [SEL_W-1:0]      sel,
  input  logic [NUM_DRIVES-1:0] attached,
  input  logic [NUM_DRIVES-1:0] active,
  output logic                  sel_attached,
  output logic                  sel_active
);
  logic [NUM_DRIVES-1:0] hit;

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_hit
    assign hit[g] = (sel == SEL_W'(g));
  end

  assign sel_attached = |(hit & attached);
  assign sel_active   = |(hit & active);
endmodule

// File: rtl/dkc_status_unit.sv
module dkc_status_unit
  import dkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_sta,
  input  logic              refuse,
  input  logic              clr_ctl,
  input  logic              probe,
  input  logic              sel_attached,
  input  logic              sel_active,
  input  logic [WORD_W-1:0] ext_set,
  input  logic              busy_set,
  input  logic              busy_clr,
  input  logic              irq_en_next,
  output logic [WORD_W-1:0] sta_q,
  output logic [WORD_W-1:0] sta_next,
  output logic              busy_q,
  output logic              irq_q
);
  logic busy_next;
  logic irq_next;

  always_comb begin
    sta_next = sta_q;
    if (clr_sta) sta_next = '0;
    if (refuse)  sta_next[ST_BUSYERR] = 1'b1;
    if (probe) begin
      sta_next[ST_NRDY] = !sel_attached;
      sta_next[ST_HMOV] = sel_active;
    end
    sta_next = sta_next | ext_set;
  end

  always_comb begin
    busy_next = (busy_q && !busy_clr) || busy_set;
    if (clr_ctl) busy_next = 1'b0;
  end

  assign irq_next = (|(sta_next & ATTN_MASK)) && irq_en_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sta_q  <= sta_next;
      busy_q <= busy_next;
      irq_q  <= irq_next;
    end
  end
endmodule

// File: rtl/dkc_launch_issue.sv
module dkc_launch_issue
  import dkc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_xfer,
  input  logic              go_recal,
  input  logic              clr_ctl,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic              cmd_cyhi,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [CYL_W-2:0]  ac_cyl,
  output logic              go_q,
  output logic [FUNC_W-1:0] func_q,
  output logic [CYL_W-1:0]  cyl_q,
  output logic [SEL_W-1:0]  drv_q,
  output logic              cancel_q
);
  logic              go_any;
  logic [FUNC_W-1:0] func_d;
  logic [CYL_W-1:0]  cyl_d;

  assign go_any = go_xfer || go_recal;
  assign func_d = go_recal ? FN_SEEK : cmd_func;
  assign cyl_d  = go_recal ? '0 : {cmd_cyhi, ac_cyl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      func_q   <= '0;
      cyl_q    <= '0;
      drv_q    <= '0;
      cancel_q <= 1'b0;
    end else begin
      go_q     <= go_any;
      cancel_q <= clr_ctl;
      if (go_any) begin
        func_q <= func_d;
        cyl_q  <= cyl_d;
        drv_q  <= cmd_sel;
      end else begin
        func_q <= '0;
        cyl_q  <= '0;
        drv_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/dkc_iot_decoder.sv
module dkc_iot_decoder
  import dkc_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int SEL_W = $clog2(NUM_DRIVES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iot_valid,
  input  logic [2:0]            iot_op,
  input  logic [WORD_W-1:0]     iot_ac,
  output logic                  rsp_valid,
  output logic                  rsp_skip,
  output logic [WORD_W-1:0]     rsp_ac,
  output logic                  irq,
  input  logic [NUM_DRIVES-1:0] drv_attached,
  input  logic [NUM_DRIVES-1:0] drv_active,
  input  logic [WORD_W-1:0]     ext_sta_set,
  input  logic                  ext_busy_set,
  input  logic                  ext_busy_clr,
  output logic                  ctl_busy,
  output logic [WORD_W-1:0]     cmd_word,
  output logic [WORD_W-1:0]     disk_addr,
  output logic [WORD_W-1:0]     mem_addr,
  output logic                  go_pulse,
  output logic [FUNC_W-1:0]     go_func,
  output logic [CYL_W-1:0]      go_cyl,
  output logic [SEL_W-1:0]      go_drive,
  output logic                  cancel_all
);
  iot_ctl_t          ctl;
  logic [WORD_W-1:0] cmd_q, da_q, ma_q;
  logic [WORD_W-1:0] cmd_next;
  logic [WORD_W-1:0] sta_q, sta_next;
  logic              busy_q, irq_q;
  logic              sel_att, sel_act;
  logic              rsp_valid_q, rsp_skip_q;
  logic [WORD_W-1:0] rsp_ac_q;

  dkc_op_decode u_dec (
    .valid (iot_valid),
    .op    (iot_op),
    .mode  (iot_ac[1:0]),
    .busy  (busy_q),
    .ctl   (ctl)
  );

  dkc_drive_probe #(.NUM_DRIVES(NUM_DRIVES)) u_probe (
    .sel          (cmd_q[SEL_LSB +: SEL_W]),
    .attached     (drv_attached),
    .active       (drv_active),
    .sel_attached (sel_att),
    .sel_active   (sel_act)
  );

  always_comb begin
    cmd_next = cmd_q;
    if (ctl.clr_ctl) cmd_next = '0;
    if (ctl.ld_cmd)  cmd_next = iot_ac;
  end

  dkc_status_unit u_sta (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_sta      (ctl.clr_sta),
    .refuse       (ctl.refuse),
    .clr_ctl      (ctl.clr_ctl),
    .probe        (ctl.probe),
    .sel_attached (sel_att),
    .sel_active   (sel_act),
    .ext_set      (ext_sta_set),
    .busy_set     (ext_busy_set),
    .busy_clr     (ext_busy_clr),
    .irq_en_next  (cmd_next[IE_BIT]),
    .sta_q        (sta_q),
    .sta_next     (sta_next),
    .busy_q       (busy_q),
    .irq_q        (irq_q)
  );

  dkc_launch_issue #(.SEL_W(SEL_W)) u_go (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_xfer  (ctl.go_xfer),
    .go_recal (ctl.go_recal),
    .clr_ctl  (ctl.clr_ctl),
    .cmd_func (cmd_q[FUNC_LSB +: FUNC_W]),
    .cmd_cyhi (cmd_q[CYHI_BIT]),
    .cmd_sel  (cmd_q[SEL_LSB +: SEL_W]),
    .ac_cyl   (iot_ac[WORD_W-1:DA_CYL_LSB]),
    .go_q     (go_pulse),
    .func_q   (go_func),
    .cyl_q    (go_cyl),
    .drv_q    (go_drive),
    .cancel_q (cancel_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      da_q        <= '0;
      ma_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_skip_q  <= 1'b0;
      rsp_ac_q    <= '0;
    end else begin
      cmd_q <= cmd_next;
      if (ctl.clr_ctl) begin
        da_q <= '0;
        ma_q <= '0;
      end else begin
        if (ctl.ld_da) da_q <= iot_ac;
        if (ctl.ld_ma) ma_q <= iot_ac;
      end
      rsp_valid_q <= iot_valid;
      rsp_skip_q  <= ctl.attn_skip && (|(sta_q & ATTN_MASK));
      rsp_ac_q    <= ctl.probe ? sta_next : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_skip  = rsp_skip_q;
  assign rsp_ac    = rsp_ac_q;
  assign irq       = irq_q;
  assign ctl_busy  = busy_q;
  assign cmd_word  = cmd_q;
  assign disk_addr = da_q;
  assign mem_addr  = ma_q;
endmodule

// File: rtl/dkc_iot_checker.sv
module dkc_iot_checker
  import dkc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              iot_valid,
  input logic [2:0]        iot_op,
  input logic              rsp_valid,
  input logic              rsp_skip,
  input logic [WORD_W-1:0] rsp_ac,
  input logic              irq,
  input logic [WORD_W-1:0] sta,
  input logic              busy,
  input logic [WORD_W-1:0] cmd,
  input logic [WORD_W-1:0] da,
  input logic [WORD_W-1:0] ma,
  input logic              go,
  input logic              cancel
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_SKIP_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(iot_valid && iot_op == 3'd1) |-> rsp_skip == ($past(|(sta & ATTN_MASK)))); // R1
  AST_SKIP_ONLY_OP1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && rsp_skip |-> $past(iot_op) == 3'd1); // R1
  AST_CLEAR_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cancel |-> cmd == '0 && da == '0 && ma == '0 && !busy); // R3
  AST_GO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && go |-> $past(iot_valid) && !$past(busy) && ($past(iot_op) == 3'd2 || $past(iot_op) == 3'd3)); // R12
  AST_REFUSE_MA: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(iot_valid && iot_op == 3'd4 && busy) |-> $stable(ma) && sta[ST_BUSYERR]); // R7
  AST_REFUSE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(iot_valid && iot_op == 3'd6 && busy) |-> $stable(cmd) && sta[ST_BUSYERR]); // R7
  AST_AC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed && rsp_valid && $past(iot_op) != 3'd5 |-> rsp_ac == '0); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq == ((|(sta & ATTN_MASK)) && cmd[IE_BIT])); // R9
endmodule

bind dkc_iot_decoder dkc_iot_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iot_valid (iot_valid),
  .iot_op    (iot_op),
  .rsp_valid (rsp_valid),
  .rsp_skip  (rsp_skip),
  .rsp_ac    (rsp_ac),
  .irq       (irq),
  .sta       (sta_q),
  .busy      (busy_q),
  .cmd       (cmd_q),
  .da        (da_q),
  .ma        (ma_q),
  .go        (go_pulse),
  .cancel    (cancel_all)
);

// File: tb/tb_dkc_iot_decoder.sv
module tb_dkc_iot_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [2:0]  iot_op = '0;
  logic [11:0] iot_ac = '0;
  logic        rsp_valid, rsp_skip, irq, ctl_busy, go_pulse, cancel_all;
  logic [11:0] rsp_ac, cmd_word, disk_addr, mem_addr;
  logic [3:0]  drv_attached = '0, drv_active = '0;
  logic [11:0] ext_sta_set = '0;
  logic        ext_busy_set = 1'b0, ext_busy_clr = 1'b0;
  logic [2:0]  go_func;
  logic [7:0]  go_cyl;
  logic [1:0]  go_drive;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [11:0] m_sta, m_cmd, m_da, m_ma;
  bit          m_busy;

  always #10 clk = ~clk;

  dkc_iot_decoder #(.NUM_DRIVES(4)) dut (
    .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_op(iot_op), .iot_ac(iot_ac),
    .rsp_valid(rsp_valid), .rsp_skip(rsp_skip), .rsp_ac(rsp_ac), .irq(irq),
    .drv_attached(drv_attached), .drv_active(drv_active), .ext_sta_set(ext_sta_set),
    .ext_busy_set(ext_busy_set), .ext_busy_clr(ext_busy_clr), .ctl_busy(ctl_busy),
    .cmd_word(cmd_word), .disk_addr(disk_addr), .mem_addr(mem_addr),
    .go_pulse(go_pulse), .go_func(go_func), .go_cyl(go_cyl), .go_drive(go_drive),
    .cancel_all(cancel_all)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq();
    return ((m_sta & 12'o4177) != 0) && m_cmd[8];
  endfunction

  task automatic check_regs(input string tag);
    chk({tag, " cmd"}, 32'(cmd_word), 32'(m_cmd));
    chk({tag, " da"}, 32'(disk_addr), 32'(m_da));
    chk({tag, " ma"}, 32'(mem_addr), 32'(m_ma));
    chk({tag, " busy R13"}, 32'(ctl_busy), 32'(m_busy));
    chk({tag, " irq R9"}, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic iot(input logic [2:0] op, input logic [11:0] ac);
    bit          e_skip = 0, e_go = 0, e_cancel = 0;
    logic [11:0] e_ac = '0;
    logic [2:0]  e_func = '0;
    logic [7:0]  e_cyl = '0;
    logic [1:0]  e_drv = '0;
    int          sel;
    sel = int'(m_cmd[2:1]);
    case (op)
      3'd1: e_skip = (m_sta & 12'o4177) != 0;                       // R1
      3'd2: begin                                                   // R2 R3 R4
        m_sta = '0;
        case (ac[1:0])
          2'd0: if (m_busy) m_sta[6] = 1'b1;
          2'd1: begin m_cmd = '0; m_da = '0; m_ma = '0; m_busy = 0; e_cancel = 1; end
          2'd2: if (m_busy) m_sta[6] = 1'b1;
                else begin e_go = 1; e_func = 3'd3; e_cyl = '0; e_drv = m_cmd[2:1]; end
          default: ;
        endcase
      end
      3'd3: if (m_busy) m_sta[6] = 1'b1;                            // R7
            else begin                                              // R5
              m_da = ac; e_go = 1; e_func = m_cmd[11:9];
              e_cyl = {m_cmd[0], ac[11:5]}; e_drv = m_cmd[2:1];
            end
      3'd4: if (m_busy) m_sta[6] = 1'b1; else m_ma = ac;            // R6 R7
      3'd5: begin                                                   // R8
        m_sta[10] = drv_active[sel];
        m_sta[7]  = !drv_attached[sel];
        e_ac = m_sta;
      end
      3'd6: if (m_busy) m_sta[6] = 1'b1;                            // R6 R7
            else begin m_cmd = ac; m_sta = '0; end
      default: ;                                                    // R10
    endcase
    @(negedge clk);
    iot_valid = 1'b1; iot_op = op; iot_ac = ac;
    @(negedge clk);
    iot_valid = 1'b0;
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R1 skip", 32'(rsp_skip), 32'(e_skip));
    chk("R10 R8 rsp_ac", 32'(rsp_ac), 32'(e_ac));
    chk("R12 go_pulse", 32'(go_pulse), 32'(e_go));
    chk("R3 cancel", 32'(cancel_all), 32'(e_cancel));
    if (e_go) begin
      chk("R5 R4 go_func", 32'(go_func), 32'(e_func));
      chk("R5 R4 go_cyl", 32'(go_cyl), 32'(e_cyl));
      chk("R5 R4 go_drive", 32'(go_drive), 32'(e_drv));
    end
    check_regs("R6 R7");
    @(negedge clk);
    chk("R12 rsp one cycle", 32'(rsp_valid), 32'd0);
    chk("R12 go one cycle", 32'(go_pulse), 32'd0);
  endtask

  task automatic busy_pulse(input bit set);
    @(negedge clk);
    if (set) ext_busy_set = 1'b1; else ext_busy_clr = 1'b1;
    @(negedge clk);
    ext_busy_set = 1'b0; ext_busy_clr = 1'b0;
    m_busy = set;
    chk("R13 busy strobe", 32'(ctl_busy), 32'(m_busy));
  endtask

  task automatic inject(input logic [11:0] bits);
    @(negedge clk);
    ext_sta_set = bits;
    @(negedge clk);
    ext_sta_set = '0;
    m_sta = m_sta | bits;
    chk("R13 R9 irq after inject", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic check_reset_state();
    chk("R11 cmd", 32'(cmd_word), 32'd0);
    chk("R11 da", 32'(disk_addr), 32'd0);
    chk("R11 ma", 32'(mem_addr), 32'd0);
    chk("R11 busy", 32'(ctl_busy), 32'd0);
    chk("R11 irq", 32'(irq), 32'd0);
    chk("R11 rsp", 32'(rsp_valid), 32'd0);
    chk("R11 go", 32'(go_pulse), 32'd0);
    chk("R11 cancel", 32'(cancel_all), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_sta = '0; m_cmd = '0; m_da = '0; m_ma = '0; m_busy = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    // directed: full cylinder with high bit, enable set
    iot(3'd6, 12'o7401);
    iot(3'd3, 12'o7777);
    inject(12'o4000);
    iot(3'd1, 12'o0000);

    for (int i = 0; i < 320; i++) begin
      @(negedge clk);
      drv_attached = 4'(i ^ (i >> 4));
      drv_active   = 4'(i >> 4);
      if (i % 5 == 0) inject(12'((i * 613) & 12'o4377));
      if (i % 3 == 1) busy_pulse(1'b1);
      for (int op = 0; op < 8; op++)
        iot(3'(op), 12'((i * 1103 + op * 409 + 291) & 4095));
      if (m_busy) busy_pulse(1'b0);
    end

    // R11: reset in the middle of activity
    iot(3'd6, 12'o0400);
    iot(3'd4, 12'o1234);
    inject(12'o0001);
    busy_pulse(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    m_sta = '0; m_cmd = '0; m_da = '0; m_ma = '0; m_busy = 0;
    iot(3'd5, 12'o0000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule